// File: doc/BRIEF.md
# DRAM Initialization Command Sequencer

This block takes an SDRAM device from power-up to normal operation without software involvement. A strap input picks one of two fixed command orderings, one for DDR1 parts and one for DDR2 parts, and the strap is captured when a start pulse is accepted. For each step the sequencer raises a one-cycle command strobe with a one-hot command code toward the downstream DRAM command port. On mode-register and extended-mode-register updates it also presents the value to be written on its mode outputs.

Each step is followed by a programmable quiet interval. A long interval is used for the main steps and a short one for the two DDR2 preamble steps. After the last step and its interval, the block enables periodic refresh with a fixed interval, loads the default DQS delay tap for both byte lanes, and then raises a done flag. The done flag stays high until the next start. A start pulse received during a run is ignored. A start pulse received while done is high begins a new run.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, cmd_vld, cmd_code, mode_val, emode_val, ref_en, ref_interval, both taps and done are all zero.
- R2: Each command strobe lasts exactly one cycle. While it is high, cmd_code has exactly one bit set, with this encoding: bit 0 mode register update, bit 1 extended mode update, bit 2 auto refresh, bit 3 precharge all, bit 4 extended mode 2 update, bit 5 extended mode 3 update. While the strobe is low, cmd_code is zero.
- R3: With the strap low (DDR1), the strobes come in this order: precharge, extended-mode update with 0x000, mode update with 0x133, precharge, auto refresh, auto refresh, mode update with 0x033.
- R4: With the strap high (DDR2), the strobes come in this order: extended-mode-2 update, extended-mode-3 update, precharge, extended-mode-2 update, extended-mode-3 update, extended-mode update with 0x402, mode update with 0x143, precharge, auto refresh, auto refresh, mode update with 0x043, extended-mode update with 0x782, extended-mode update with 0x402.
- R5: mode_val takes a new value in the same cycle as a mode-update strobe, and emode_val in the same cycle as an extended-mode-update strobe. Both hold their values at all other times.
- R6: Consecutive strobes are WAIT_MAIN+1 cycles apart. The exception is a strobe that follows one of the first two DDR2 steps, which comes WAIT_PRE+1 cycles after that step.
- R7: WAIT_MAIN+1 cycles after the last strobe, ref_en goes to 1, ref_interval to 312, and both taps to 0x20 (DDR1) or 0x10 (DDR2). One cycle after that, done rises and stays high with no further strobes.
- R8: A start pulse during a run has no effect, and neither does a change of the strap after start has been accepted. The run continues with the captured flow and finishes once.
- R9: A start pulse while done is high begins a new run. In the following cycle, done and ref_en are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted when idle or done |
| ddr2_sel | input | 1 | Memory type strap: 0 DDR1, 1 DDR2; captured at start |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_code | output | 6 | One-hot command code |
| mode_val | output | MRW | Mode register value |
| emode_val | output | MRW | Extended mode register value |
| ref_en | output | 1 | Periodic refresh enable |
| ref_interval | output | REFW | Refresh interval setting |
| tap_lane0 | output | TAPW | DQS delay tap, byte lane 0 |
| tap_lane1 | output | TAPW | DQS delay tap, byte lane 1 |
| done | output | 1 | Sequence complete |

## Verification
A start pulse can arrive in the same cycle as a command strobe or a step countdown, which makes it compete with step issue for control of the sequencer. The bench provokes this by pulsing start and flipping the strap partway through both DDR1 and DDR2 runs. It judges the result by the scoreboard: the strobe list must match the originally captured flow exactly, with unchanged spacing and exactly one completion. It also starts a new run from the done state and checks that done and refresh drop in the following cycle.

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int WAIT_MAIN    = 200,
  parameter int WAIT_PRE     = 20,
  parameter int MRW          = 13,
  parameter int TAPW         = 6,
  parameter int REFW         = 10,
  parameter int REF_INTERVAL = 312,
  parameter int TAP_DDR1     = 32,
  parameter int TAP_DDR2     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ddr2_sel,
  output logic            cmd_vld,
  output logic [5:0]      cmd_code,
  output logic [MRW-1:0]  mode_val,
  output logic [MRW-1:0]  emode_val,
  output logic            ref_en,
  output logic [REFW-1:0] ref_interval,
  output logic [TAPW-1:0] tap_lane0,
  output logic [TAPW-1:0] tap_lane1,
  output logic            done
);
  localparam int WMAX = (WAIT_MAIN > WAIT_PRE) ? WAIT_MAIN : WAIT_PRE;
  localparam int CW   = $clog2(WMAX + 1);
  localparam logic [5:0] K_MR = 6'b000001, K_EM = 6'b000010, K_AR = 6'b000100,
                         K_PA = 6'b001000, K_E2 = 6'b010000, K_E3 = 6'b100000;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_DONE} st_t;

  // step word: {short wait, command, value}
  function automatic logic [19:0] step_of(input logic d2, input logic [3:0] i);
    logic [19:0] s;
    s = '0;
    if (!d2) begin
      case (i)
        4'd0: s = {1'b0, K_PA, 13'h000};
        4'd1: s = {1'b0, K_EM, 13'h000};
        4'd2: s = {1'b0, K_MR, 13'h133};
        4'd3: s = {1'b0, K_PA, 13'h000};
        4'd4: s = {1'b0, K_AR, 13'h000};
        4'd5: s = {1'b0, K_AR, 13'h000};
        4'd6: s = {1'b0, K_MR, 13'h033};
        default: s = '0;
      endcase
    end else begin
      case (i)
        4'd0:  s = {1'b1, K_E2, 13'h000};
        4'd1:  s = {1'b1, K_E3, 13'h000};
        4'd2:  s = {1'b0, K_PA, 13'h000};
        4'd3:  s = {1'b0, K_E2, 13'h000};
        4'd4:  s = {1'b0, K_E3, 13'h000};
        4'd5:  s = {1'b0, K_EM, 13'h402};
        4'd6:  s = {1'b0, K_MR, 13'h143};
        4'd7:  s = {1'b0, K_PA, 13'h000};
        4'd8:  s = {1'b0, K_AR, 13'h000};
        4'd9:  s = {1'b0, K_AR, 13'h000};
        4'd10: s = {1'b0, K_MR, 13'h043};
        4'd11: s = {1'b0, K_EM, 13'h782};
        4'd12: s = {1'b0, K_EM, 13'h402};
        default: s = '0;
      endcase
    end
    return s;
  endfunction

  st_t st;
  logic d2;
  logic [3:0] idx;
  logic [CW-1:0] cnt;
  logic [19:0] step;
  logic [3:0] nsteps;

  assign step   = step_of(d2, idx);
  assign nsteps = d2 ? 4'd13 : 4'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; d2 <= 1'b0; idx <= '0; cnt <= '0;
      cmd_vld <= 1'b0; cmd_code <= '0; mode_val <= '0; emode_val <= '0;
      ref_en <= 1'b0; ref_interval <= '0; tap_lane0 <= '0; tap_lane1 <= '0;
      done <= 1'b0;
    end else begin
      cmd_vld  <= 1'b0;
      cmd_code <= '0;
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st <= S_RUN; d2 <= ddr2_sel; idx <= '0; cnt <= '0;
            done <= 1'b0; ref_en <= 1'b0;
          end
        S_RUN:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (idx == nsteps) begin
            ref_en       <= 1'b1;
            ref_interval <= REFW'(REF_INTERVAL);
            tap_lane0    <= d2 ? TAPW'(TAP_DDR2) : TAPW'(TAP_DDR1);
            tap_lane1    <= d2 ? TAPW'(TAP_DDR2) : TAPW'(TAP_DDR1);
            st           <= S_FIN;
          end else begin
            cmd_vld  <= 1'b1;
            cmd_code <= step[18:13];
            if (step[13]) mode_val  <= MRW'(step[12:0]);
            if (step[14]) emode_val <= MRW'(step[12:0]);
            cnt <= step[19] ? CW'(WAIT_PRE) : CW'(WAIT_MAIN);
            idx <= idx + 1'b1;
          end
        S_FIN: begin done <= 1'b1; st <= S_DONE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> $countones(cmd_code) == 1); // R2
  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |-> cmd_code == '0); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && cmd_code[0]) |=> $stable(mode_val) || (cmd_vld && cmd_code[0])); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R7
  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_vld && ref_en && ref_interval == REFW'(REF_INTERVAL)); // R7
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && !ref_en); // R9
endmodule

// File: tb/sim_dram_init_seq.sv
`timescale 1ns/1ps
module sim_dram_init_seq;
  localparam int WM = 6, WP = 2;
  localparam logic [5:0] K_MR = 6'b000001, K_EM = 6'b000010, K_AR = 6'b000100,
                         K_PA = 6'b001000, K_E2 = 6'b010000, K_E3 = 6'b100000;

  logic clk = 0, rst_n = 0, start = 0, ddr2_sel = 0;
  logic cmd_vld, ref_en, done;
  logic [5:0] cmd_code;
  logic [12:0] mode_val, emode_val;
  logic [9:0] ref_interval;
  logic [5:0] tap_lane0, tap_lane1;

  dram_init_seq #(.WAIT_MAIN(WM), .WAIT_PRE(WP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ddr2_sel(ddr2_sel),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code), .mode_val(mode_val),
    .emode_val(emode_val), .ref_en(ref_en), .ref_interval(ref_interval),
    .tap_lane0(tap_lane0), .tap_lane1(tap_lane1), .done(done));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_cyc = 0;
  bit idle_bad = 0;
  logic [5:0] q_cmd[$];
  int q_val[$], q_gap[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] c, input int v, input int g, input string t);
    q_cmd.push_back(c); q_val.push_back(v); q_gap.push_back(g); q_tag.push_back(t);
  endtask

  task automatic exp_ddr1();
    push(K_PA, 0, 0, "R3"); push(K_EM, 'h000, WM+1, "R3"); push(K_MR, 'h133, WM+1, "R3");
    push(K_PA, 0, WM+1, "R3"); push(K_AR, 0, WM+1, "R3"); push(K_AR, 0, WM+1, "R3");
    push(K_MR, 'h033, WM+1, "R3");
  endtask

  task automatic exp_ddr2();
    push(K_E2, 0, 0, "R4"); push(K_E3, 0, WP+1, "R4"); push(K_PA, 0, WP+1, "R6");
    push(K_E2, 0, WM+1, "R4"); push(K_E3, 0, WM+1, "R4"); push(K_EM, 'h402, WM+1, "R4");
    push(K_MR, 'h143, WM+1, "R4"); push(K_PA, 0, WM+1, "R4"); push(K_AR, 0, WM+1, "R4");
    push(K_AR, 0, WM+1, "R4"); push(K_MR, 'h043, WM+1, "R4"); push(K_EM, 'h782, WM+1, "R4");
    push(K_EM, 'h402, WM+1, "R4");
  endtask

  // monitor: pop expected strobes and compare
  always @(negedge clk) begin
    if (rst_n && !cmd_vld && cmd_code != 0) idle_bad = 1;
    if (rst_n && cmd_vld) begin
      if (q_cmd.size() == 0) chk(0, "R8 unexpected strobe", cmd_code, 0);
      else begin
        logic [5:0] ec; int ev, eg; string t;
        ec = q_cmd.pop_front(); ev = q_val.pop_front(); eg = q_gap.pop_front(); t = q_tag.pop_front();
        chk(cmd_code == ec, {t, " R2 code"}, cmd_code, ec);
        if (ec == K_MR) chk(mode_val == 13'(ev), {t, " R5 mode"}, mode_val, ev);
        if (ec == K_EM) chk(emode_val == 13'(ev), {t, " R5 emode"}, emode_val, ev);
        if (eg != 0) chk(cyc - last_cyc == eg, "R6 spacing", cyc - last_cyc, eg);
      end
      last_cyc = cyc;
    end
  end

  task automatic run(input logic d2, input bit disturb);
    int ref_cyc, done_cyc;
    int tap;
    tap = d2 ? 'h10 : 'h20;
    if (d2) exp_ddr2(); else exp_ddr1();
    @(negedge clk); ddr2_sel = d2; start = 1;
    @(negedge clk); start = 0;
    chk(!done && !ref_en, "R9 restart clears done/ref", {done, ref_en}, 0);
    if (disturb) begin
      repeat (10) @(negedge clk);
      start = 1; ddr2_sel = !d2;
      @(negedge clk); start = 0;
    end
    ref_cyc = -1;
    while (!done) begin
      @(negedge clk);
      if (ref_en && ref_cyc < 0) ref_cyc = cyc;
    end
    done_cyc = cyc;
    chk(q_cmd.size() == 0, d2 ? "R4 all strobes seen" : "R3 all strobes seen", q_cmd.size(), 0);
    chk(ref_cyc - last_cyc == WM + 1, "R7 refresh timing", ref_cyc - last_cyc, WM + 1);
    chk(done_cyc - last_cyc == WM + 2, "R7 done timing", done_cyc - last_cyc, WM + 2);
    chk(ref_en && ref_interval == 312, "R7 refresh setting", ref_interval, 312);
    chk(tap_lane0 == 6'(tap) && tap_lane1 == 6'(tap), "R7 taps", {tap_lane1, tap_lane0}, {6'(tap), 6'(tap)});
    chk(mode_val == (d2 ? 13'h043 : 13'h033), "R5 mode held", mode_val, d2 ? 'h043 : 'h033);
    chk(emode_val == (d2 ? 13'h402 : 13'h000), "R5 emode held", emode_val, d2 ? 'h402 : 0);
    repeat (5) @(negedge clk);
    chk(done && !cmd_vld, "R7 done sticky", done, 1);
    chk(!idle_bad, "R2 code zero when idle", idle_bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_vld && cmd_code == 0 && mode_val == 0 && emode_val == 0 && !ref_en &&
        ref_interval == 0 && tap_lane0 == 0 && tap_lane1 == 0 && !done,
        "R1 reset state", {cmd_vld, ref_en, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!cmd_vld && !done, "R1 idle after reset", {cmd_vld, done}, 0);
    run(1'b0, 1'b0);
    run(1'b1, 1'b0);
    run(1'b1, 1'b1);  // R8 start and strap change mid-run
    run(1'b0, 1'b1);  // R8
    summary();
  end
endmodule